// File: doc/BRIEF.md
# CAN Time Quantum Prescaler

This block turns the bit-timing configuration byte of a CAN controller into two things the bit-timing state machine needs. The first is a one-cycle tick, the time quantum (Tq), that divides the module clock by a programmable ratio. The second is a phase correction that has been limited to the configured jump width. Software sets the byte through a small write port. A write takes effect only while the controller is in initialization mode, and the byte can be read back at any time.

On every cycle the edge detector supplies a signed phase error, in Tq. The block passes this value through unchanged when it lies within the jump limit. Otherwise it saturates the value at plus or minus the limit. The result is combinational, so the segment machine sees it in the same cycle. The Tq counter is held at zero during initialization mode. It therefore starts a fresh period on the first clock after the controller leaves that mode.

Top module: `can_tq_prescaler`

## Requirements
- R1: After reset the configuration byte reads back as 0x00. That value means a jump limit of 1 Tq and a division ratio of 1.
- R2: When `cfg_wr_en` is high on a clock edge and `init_mode` is high, `cfg_wr_data` is stored. From the next cycle all eight bits are visible on `cfg_rd_data`.
- R3: A write attempted while `init_mode` is low is ignored, and `cfg_rd_data` keeps its previous value.
- R4: Bits 7:6 of the byte hold the jump-width code. Codes 0, 1, 2 and 3 give a jump limit of 1, 2, 3 and 4 Tq.
- R5: Bits 5:0 of the byte hold the prescale value P. Outside initialization mode, `tq_tick` is high for exactly one cycle in every P+1 cycles. With P = 0 it is high on every cycle.
- R6: `tq_tick` stays low on every cycle in which `init_mode` is high.
- R7: Count cycle 1 as the first cycle with `init_mode` low after a period in initialization mode. The first tick then falls in cycle P+1.
- R8: When `phase_err` lies from -L to +L inclusive, where L is the jump limit, `jump_corr` equals `phase_err` in the same cycle.
- R9: When `phase_err` exceeds +L, `jump_corr` is +L. When it is below -L, `jump_corr` is -L.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| init_mode | input | 1 | High while the controller is in initialization mode |
| cfg_wr_en | input | 1 | Write strobe for the configuration byte |
| cfg_wr_data | input | 8 | Byte to store: [7:6] jump code, [5:0] prescale |
| cfg_rd_data | output | 8 | Current configuration byte |
| phase_err | input | 6 | Signed phase error in Tq from the edge detector |
| tq_tick | output | 1 | One-cycle time-quantum pulse |
| jump_corr | output | 6 | Signed phase correction, limited to ±jump limit |

## Verification
Some properties are checked by assertions on every cycle. A write is never accepted outside initialization mode. The counter never passes the prescale value, and it wraps to zero after each tick. No tick appears in initialization mode. The counter is zero on the first cycle after that mode ends. The correction never leaves ±L, and it equals the error whenever the error lies inside that range. Other behaviour can only be shown by the bench's scenarios. These are the exact tick spacing for prescale values 0, 1, 5, 13 and 63, the position of the first tick after initialization ends, and the mapping of each jump code to its limit. The bench also checks the read-back of randomly timed writes against a model of the register.

// File: rtl/can_tq_pkg.sv
package can_tq_pkg;
    localparam int SJW_BITS = 2;
    localparam int BRP_BITS = 6;
    localparam int CFG_BITS = SJW_BITS + BRP_BITS;

    typedef struct packed {
        logic [SJW_BITS-1:0] sjw;
        logic [BRP_BITS-1:0] brp;
    } tq_cfg_t;
endpackage

// File: rtl/can_tq_cfg_reg.sv
module can_tq_cfg_reg
    import can_tq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                init_mode,
    input  logic                wr_en,
    input  logic [CFG_BITS-1:0] wr_data,
    output tq_cfg_t             cfg_q
);
    tq_cfg_t cfg_d;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en && init_mode) begin
            cfg_d = tq_cfg_t'(wr_data);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    // Outside initialization mode the byte must not move.
    assert_write_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !init_mode |=> $stable(cfg_q));
    // An accepted write lands in the register on the following cycle.
    assert_write_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (init_mode && wr_en) |=> (cfg_q == tq_cfg_t'($past(wr_data))));
endmodule

// File: rtl/can_tq_divider.sv
module can_tq_divider #(
    parameter int BRP_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_mode,
    input  logic [BRP_W-1:0] brp,
    output logic             tick
);
    typedef struct packed {
        logic [BRP_W-1:0] cnt;
    } div_state_t;

    div_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = !init_mode && (st_q.cnt == brp);
        if (init_mode || tick) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_no_tick_in_init_R6: assert property (@(posedge clk) disable iff (!rst_n)
        init_mode |-> !tick);
    assert_cnt_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !init_mode |-> (st_q.cnt <= brp));
    assert_wrap_after_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (st_q.cnt == '0));
    assert_fresh_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(init_mode) |-> (st_q.cnt == '0));
endmodule

// File: rtl/can_tq_jump_limit.sv
module can_tq_jump_limit #(
    parameter int SJW_W = 2,
    parameter int PH_W  = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [SJW_W-1:0]       sjw_code,
    input  logic signed [PH_W-1:0] err,
    output logic signed [PH_W-1:0] corr
);
    localparam int LIM_W = SJW_W + 1;

    logic [LIM_W-1:0]       lim_u;
    logic signed [PH_W-1:0] lim_pos;
    logic signed [PH_W-1:0] lim_neg;

    always_comb begin
        lim_u   = {1'b0, sjw_code} + 1'b1;
        lim_pos = signed'(PH_W'(lim_u));
        lim_neg = -lim_pos;
        if (err > lim_pos)      corr = lim_pos;
        else if (err < lim_neg) corr = lim_neg;
        else                    corr = err;
    end

    assert_corr_bounded_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (corr <= signed'(PH_W'(sjw_code) + PH_W'(1)))
        && (corr >= -signed'(PH_W'(sjw_code) + PH_W'(1))));
    assert_inside_passes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((err <= signed'(PH_W'(sjw_code) + PH_W'(1)))
         && (err >= -signed'(PH_W'(sjw_code) + PH_W'(1)))) |-> (corr == err));
endmodule

// File: rtl/can_tq_prescaler.sv
module can_tq_prescaler
    import can_tq_pkg::*;
#(
    parameter int PH_W = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       init_mode,
    input  logic                       cfg_wr_en,
    input  logic [CFG_BITS-1:0]        cfg_wr_data,
    output logic [CFG_BITS-1:0]        cfg_rd_data,
    input  logic signed [PH_W-1:0]     phase_err,
    output logic                       tq_tick,
    output logic signed [PH_W-1:0]     jump_corr
);
    tq_cfg_t cfg_q;

    can_tq_cfg_reg i_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .init_mode (init_mode),
        .wr_en     (cfg_wr_en),
        .wr_data   (cfg_wr_data),
        .cfg_q     (cfg_q)
    );

    can_tq_divider #(.BRP_W(BRP_BITS)) i_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .init_mode (init_mode),
        .brp       (cfg_q.brp),
        .tick      (tq_tick)
    );

    can_tq_jump_limit #(.SJW_W(SJW_BITS), .PH_W(PH_W)) i_jump (
        .clk      (clk),
        .rst_n    (rst_n),
        .sjw_code (cfg_q.sjw),
        .err      (phase_err),
        .corr     (jump_corr)
    );

    assign cfg_rd_data = cfg_q;
endmodule

// File: tb/test_can_tq_prescaler.sv
module test_can_tq_prescaler;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic init_mode = 1'b1;
    logic cfg_wr_en = 1'b0;
    logic [7:0] cfg_wr_data = '0;
    logic [7:0] cfg_rd_data;
    logic signed [5:0] phase_err = '0;
    logic tq_tick;
    logic signed [5:0] jump_corr;

    int total = 0;
    int bad = 0;
    logic [7:0] model = '0;

    always #5 clk = ~clk;

    can_tq_prescaler i_can_tq_prescaler (
        .clk(clk), .rst_n(rst_n), .init_mode(init_mode),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
        .cfg_rd_data(cfg_rd_data), .phase_err(phase_err),
        .tq_tick(tq_tick), .jump_corr(jump_corr)
    );

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_clamp(int e, int code);
        int lim = code + 1;
        if (e > lim) return lim;
        if (e < -lim) return -lim;
        return e;
    endfunction

    task automatic write_cfg(logic [7:0] v);
        @(negedge clk);
        init_mode = 1'b1; cfg_wr_en = 1'b1; cfg_wr_data = v;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        model = v;
    endtask

    task automatic clamp_probe(string req, int e);
        phase_err = 6'(e);
        #1;
        check(req, int'(jump_corr), exp_clamp(e, int'(model[7:6])));
    endtask

    // Leave init mode and compare tq_tick against the expected spacing.
    task automatic run_ticks(int p);
        int first = -1;
        @(negedge clk);
        init_mode = 1'b0;
        for (int n = 0; n < 3 * (p + 1); n++) begin
            if (n > 0) @(negedge clk);
            #1;
            if (tq_tick && first < 0) first = n + 1;
            check("R5 tick spacing", int'(tq_tick), int'((n % (p + 1)) == p));
        end
        check("R7 first tick cycle", first, p + 1);
        @(negedge clk);
        init_mode = 1'b1;
        for (int n = 0; n < 3; n++) begin
            #1;
            check("R6 no tick in init", int'(tq_tick), 0);
            @(negedge clk);
        end
    endtask

    initial begin
        #2_000_000;
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset value", int'(cfg_rd_data), 0);
        clamp_probe("R1 reset limit 1", 20);
        check("R6 no tick in init after reset", int'(tq_tick), 0);

        // R2 full-byte read-back
        write_cfg(8'hA5);
        #1 check("R2 readback", int'(cfg_rd_data), 8'hA5);

        // R3 writes outside init mode are dropped
        @(negedge clk);
        init_mode = 1'b0; cfg_wr_en = 1'b1; cfg_wr_data = 8'h3C;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        #1 check("R3 write ignored", int'(cfg_rd_data), 8'hA5);
        init_mode = 1'b1;

        // R4 jump code mapping, R8/R9 boundaries
        for (int c = 0; c < 4; c++) begin
            write_cfg({2'(c), 6'd0});
            clamp_probe("R4 code limit", 31);
            clamp_probe("R4 code limit negative", -32);
            clamp_probe("R8 at +L", c + 1);
            clamp_probe("R8 at -L", -(c + 1));
            clamp_probe("R9 above +L", c + 2);
            clamp_probe("R9 below -L", -(c + 2));
            clamp_probe("R8 zero", 0);
        end

        // R5/R6/R7 tick spacing for several prescale values
        write_cfg(8'h00); run_ticks(0);
        write_cfg(8'h41); run_ticks(1);
        write_cfg(8'h85); run_ticks(5);
        write_cfg(8'hCD); run_ticks(13);
        write_cfg(8'h3F); run_ticks(63);

        // Random writes with random mode (R2, R3)
        for (int i = 0; i < 60; i++) begin
            logic we, im;
            logic [7:0] d;
            @(negedge clk);
            we = 1'($urandom);
            im = 1'($urandom);
            d  = 8'($urandom);
            init_mode = im; cfg_wr_en = we; cfg_wr_data = d;
            @(negedge clk);
            cfg_wr_en = 1'b0;
            if (we && im) model = d;
            #1 check(im ? "R2 random write" : "R3 random locked",
                     int'(cfg_rd_data), int'(model));
        end

        // Random phase errors against the current limit (R8, R9)
        init_mode = 1'b1;
        for (int i = 0; i < 80; i++) begin
            if (i % 20 == 0) write_cfg(8'($urandom));
            clamp_probe("R9 random clamp", int'($signed(6'($urandom))));
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule